// File: doc/BRIEF.md
# Indexed Register Window with Counter Test Mode

This block is the byte-wide, port-mapped register window of a dual-channel disk controller. The host bus can reach each channel at one of two eight-byte windows: the primary channel at offsets 0x0 to 0x7 and the secondary channel at offsets 0x8 to 0xF. Software writes a register number to the index offset of a window. It then reads or writes that register through the data offset of the same window. Each channel has its own index.

Behind each window are the following registers:
- a control byte;
- sixteen drive-timing bytes, eight per drive;
- a read-only cable-sense byte;
- two read-only views of a shared 30-bit down-counter.

The secondary window also holds the two PLL divider bytes, and these drive output pins. The counter counts down once per clock while the test-mode bit of the primary control byte is set. Software measures a clock rate with it by starting the counter, waiting, stopping it and reading the four slices. Reads return their data one clock after the request.

Top module: `ivr_window`

## Requirements
- R1: A write at window offset 1 (address 0x1 for primary, 0x9 for secondary) loads that channel's index. A read at the same offset returns the index.
- R2: At window offset 3 (address 0x3 or 0xB), a read or write reaches the register that the channel's index selects. Indices 0x0C to 0x13 (drive 0) and 0x14 to 0x1B (drive 1) are read/write timing bytes, stored separately for each channel.
- R3: Index 0x01 is a read/write control byte in each channel. Bit 6 (mask 0x40) of the primary channel's control byte enables the counter. The secondary control byte has no effect on the counter.
- R4: While the enable is set, the 30-bit counter decrements by one on every clock. While it is clear, the counter holds its value.
- R5: The counter wraps from 0 to 0x3FFFFFFF.
- R6: The counter views are read-only, and writes to them are ignored.
  - Primary index 0x20 reads counter bits 7:0, and primary index 0x21 reads {0, bits 14:8}.
  - Secondary index 0x20 reads bits 22:15, and secondary index 0x21 reads {0, bits 29:23}.
- R7: Index 0x0B reads bit 2 (mask 0x04) equal to that channel's `cable40` input, where 1 means a 40-conductor cable. Its other bits read 0, and writes are ignored.
- R8: Secondary indices 0x02 and 0x03 are read/write bytes that drive `pllF` and `pllR`. On the primary channel these indices are unimplemented.
- R9: Unimplemented indices read 0x00, and writes to them change nothing. Reads at window offsets other than 1 and 3 return 0x00.
- R10: Synchronous reset clears every register and output. It loads the counter with `CNT_INIT`, whose default is 0x3FFFFFFF.
- R11: `rdValid` is high, with `rdData`, exactly one clock after a clock with `rdEn` high, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Bus write strobe |
| rdEn | input | 1 | Bus read strobe |
| addr | input | 4 | Window offset; bit 3 selects the secondary channel |
| wrData | input | 8 | Write data |
| cable40 | input | 2 | Cable sense per channel, 1 = 40-conductor |
| rdData | output | 8 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one clock after rdEn |
| pllF | output | 8 | PLL feedback divider byte |
| pllR | output | 8 | PLL reference divider byte |

## Verification
The hardest cases to reach are the wrap from zero and the carry between the two channel slices. From reset, the counter needs about a billion cycles to get there. The bench therefore sets `CNT_INIT` to 0x8010 and then runs two timed enable windows, of exactly 0x11 and 0x8000 decrements. The first window lands on 0x7FFF, which is just below the bit-15 split between channels. The second lands on the wrap value 0x3FFFFFFF. After each window the counter is stopped and its four slices are read across both channels.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int ByteW    = 8;
  localparam int NumCh    = 2;
  localparam int AddrW    = 4;
  localparam int CntW     = 30;
  localparam int SliceW   = CntW / NumCh;
  localparam int TimCount = 16;
  localparam int TimSelW  = $clog2(TimCount);
  localparam int CableBit = 2;
  localparam int TestBit  = 6;

  localparam logic [2:0] OffIdx  = 3'd1;
  localparam logic [2:0] OffData = 3'd3;

  localparam logic [ByteW-1:0] IdxCtrl  = 8'h01;
  localparam logic [ByteW-1:0] IdxPllF  = 8'h02;
  localparam logic [ByteW-1:0] IdxPllR  = 8'h03;
  localparam logic [ByteW-1:0] IdxCable = 8'h0B;
  localparam logic [ByteW-1:0] TimBase  = 8'h0C;
  localparam logic [ByteW-1:0] TimEnd   = 8'(TimBase + TimCount);
  localparam logic [ByteW-1:0] IdxCntLo = 8'h20;
  localparam logic [ByteW-1:0] IdxCntHi = 8'h21;

  typedef struct packed {
    logic [NumCh-1:0] idxWr;
    logic [NumCh-1:0] dataWr;
    logic [NumCh-1:0] idxRd;
    logic [NumCh-1:0] dataRd;
    logic             rdAny;
  } strobe_t;
endpackage

// File: rtl/ivr_ctrl.sv
module ivr_ctrl
  import ivr_pkg::*;
(
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [AddrW-1:0] addr,
  output strobe_t          stb
);
  logic [2:0] offset;
  assign offset = addr[2:0];

  always_comb begin
    stb = '0;
    stb.rdAny = rdEn;
    for (int ch = 0; ch < NumCh; ch++) begin
      if (int'(addr[AddrW-1]) == ch) begin
        stb.idxWr[ch]  = wrEn && (offset == OffIdx);
        stb.dataWr[ch] = wrEn && (offset == OffData);
        stb.idxRd[ch]  = rdEn && (offset == OffIdx);
        stb.dataRd[ch] = rdEn && (offset == OffData);
      end
    end
  end
endmodule

// File: rtl/ivr_datapath.sv
module ivr_datapath
  import ivr_pkg::*;
#(
  parameter logic [CntW-1:0] CNT_INIT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          stb,
  input  logic [ByteW-1:0] wrData,
  input  logic [NumCh-1:0] cable40,
  output logic [ByteW-1:0] rdData,
  output logic             rdValid,
  output logic [ByteW-1:0] pllF,
  output logic [ByteW-1:0] pllR,
  output logic [CntW-1:0]  cntValue,
  output logic             testMode
);
  logic [NumCh-1:0][ByteW-1:0] idxBus;
  logic [NumCh-1:0][ByteW-1:0] rdBus;
  logic [ByteW-1:0] pllFReg, pllRReg;
  logic [CntW-1:0]  cnt;
  logic [ByteW-1:0] nextRd;

  for (genvar ch = 0; ch < NumCh; ch++) begin : gCh
    localparam bit IsPll = (ch == NumCh - 1);
    logic [ByteW-1:0]   idxReg, ctrlReg, rdVal;
    logic [ByteW-1:0]   timReg [TimCount];
    logic               timHit;
    logic [TimSelW-1:0] timSel;
    logic [SliceW-1:0]  slice;

    assign timHit = (idxReg >= TimBase) && (idxReg < TimEnd);
    assign timSel = TimSelW'(idxReg - TimBase);
    assign slice  = cnt[ch*SliceW +: SliceW];

    always_ff @(posedge clk) begin
      if (rst) begin
        idxReg  <= '0;
        ctrlReg <= '0;
        for (int i = 0; i < TimCount; i++) timReg[i] <= '0;
      end else begin
        if (stb.idxWr[ch]) idxReg <= wrData;
        if (stb.dataWr[ch]) begin
          if (idxReg == IdxCtrl) ctrlReg <= wrData;
          if (timHit) timReg[timSel] <= wrData;
        end
      end
    end

    always_comb begin
      rdVal = '0;
      case (idxReg)
        IdxCtrl:  rdVal = ctrlReg;
        IdxCable: rdVal[CableBit] = cable40[ch];
        IdxCntLo: rdVal = slice[ByteW-1:0];
        IdxCntHi: rdVal = ByteW'(slice >> ByteW);
        IdxPllF:  rdVal = IsPll ? pllFReg : '0;
        IdxPllR:  rdVal = IsPll ? pllRReg : '0;
        default:  rdVal = timHit ? timReg[timSel] : '0;
      endcase
    end

    assign idxBus[ch] = idxReg;
    assign rdBus[ch]  = rdVal;

    if (ch == 0) begin : gTest
      assign testMode = ctrlReg[TestBit];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pllFReg <= '0;
      pllRReg <= '0;
    end else if (stb.dataWr[NumCh-1]) begin
      if (idxBus[NumCh-1] == IdxPllF) pllFReg <= wrData;
      if (idxBus[NumCh-1] == IdxPllR) pllRReg <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= CNT_INIT;
    else if (testMode) cnt <= cnt - 1'b1;
  end

  always_comb begin
    nextRd = '0;
    for (int ch = 0; ch < NumCh; ch++) begin
      if (stb.idxRd[ch])  nextRd = idxBus[ch];
      if (stb.dataRd[ch]) nextRd = rdBus[ch];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdData  <= nextRd;
      rdValid <= stb.rdAny;
    end
  end

  assign pllF     = pllFReg;
  assign pllR     = pllRReg;
  assign cntValue = cnt;
endmodule

// File: rtl/ivr_window.sv
module ivr_window
  import ivr_pkg::*;
#(
  parameter logic [CntW-1:0] CNT_INIT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [AddrW-1:0] addr,
  input  logic [ByteW-1:0] wrData,
  input  logic [NumCh-1:0] cable40,
  output logic [ByteW-1:0] rdData,
  output logic             rdValid,
  output logic [ByteW-1:0] pllF,
  output logic [ByteW-1:0] pllR
);
  strobe_t         stb;
  logic [CntW-1:0] cntValue;
  logic            testMode;

  ivr_ctrl uCtrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .stb(stb)
  );

  ivr_datapath #(.CNT_INIT(CNT_INIT)) uDp (
    .clk(clk), .rst(rst), .stb(stb), .wrData(wrData), .cable40(cable40),
    .rdData(rdData), .rdValid(rdValid), .pllF(pllF), .pllR(pllR),
    .cntValue(cntValue), .testMode(testMode)
  );
endmodule

// File: rtl/ivr_window_chk.sv
module ivr_window_chk
  import ivr_pkg::*;
#(
  parameter logic [CntW-1:0] CNT_INIT = '1
) (
  input logic             clk,
  input logic             rst,
  input logic             wrEn,
  input logic             rdEn,
  input logic [AddrW-1:0] addr,
  input logic [ByteW-1:0] rdData,
  input logic             rdValid,
  input logic [ByteW-1:0] pllF,
  input logic [ByteW-1:0] pllR,
  input logic [CntW-1:0]  cntValue,
  input logic             testMode
);
  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !testMode |=> $stable(cntValue));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (testMode && cntValue != '0) |=> (cntValue == $past(cntValue) - 1'b1));

  // R5
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (testMode && cntValue == '0) |=> (cntValue == '1));

  // R11
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rdEn |=> rdValid);

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> !rdValid);

  // R9
  rd_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && addr[2:0] != OffIdx && addr[2:0] != OffData) |=> (rdData == '0));

  // R8
  pll_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && addr == {1'b1, OffData}) |=> ($stable(pllF) && $stable(pllR)));

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cntValue == CNT_INIT && pllF == '0 && pllR == '0 && !rdValid));
endmodule

bind ivr_window ivr_window_chk #(.CNT_INIT(CNT_INIT)) uChk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .rdData(rdData), .rdValid(rdValid), .pllF(pllF), .pllR(pllR),
  .cntValue(cntValue), .testMode(testMode)
);

// File: tb/ivr_window_test.sv
module ivr_window_test;
  localparam logic [29:0] Init = 30'h0000_8010;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] cable40 = 2'b01;
  logic [7:0] rdData, pllF, pllR;
  logic       rdValid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  ivr_window #(.CNT_INIT(Init)) uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .cable40(cable40), .rdData(rdData), .rdValid(rdValid),
    .pllF(pllF), .pllR(pllR)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Monitor: each returned read is compared with the oldest expectation.
  always @(negedge clk) begin
    if (!rst && rdValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: actual=rdValid=1 expected=rdValid=0 (no read pending)");
      end else begin
        check(rdData, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  task automatic opWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b0; addr = a; wrData = d;
  endtask

  task automatic opRead(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b1; addr = a;
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  task automatic opIdle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrEn = 1'b0; rdEn = 1'b0;
    end
  endtask

  task automatic regWrite(input bit sec, input logic [7:0] idx, input logic [7:0] d);
    opWrite({sec, 3'd1}, idx);
    opWrite({sec, 3'd3}, d);
  endtask

  task automatic regRead(input bit sec, input logic [7:0] idx, input logic [7:0] exp,
                         input string tag);
    opWrite({sec, 3'd1}, idx);
    opRead({sec, 3'd3}, exp, tag);
  endtask

  task automatic readCounter(input logic [29:0] c, input string tag);
    regRead(1'b0, 8'h20, c[7:0], tag);
    regRead(1'b0, 8'h21, {1'b0, c[14:8]}, tag);
    regRead(1'b1, 8'h20, c[22:15], tag);
    regRead(1'b1, 8'h21, {1'b0, c[29:23]}, tag);
  endtask

  // Enable via primary ctrl, hold K idle clocks, disable: K+1 decrements.
  task automatic runCounter(input int k);
    regWrite(1'b0, 8'h01, 8'h40);
    opIdle(k);
    opWrite(4'h3, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    check(pllF, 8'h00, "R10 pllF after reset");
    check(pllR, 8'h00, "R10 pllR after reset");
    regRead(1'b0, 8'h01, 8'h00, "R10 ctrl after reset");
    regRead(1'b1, 8'h0C, 8'h00, "R10 timing after reset");
    readCounter(Init, "R10 counter load value");

    // R1 index load and read-back
    opWrite(4'h1, 8'h15);
    opRead(4'h1, 8'h15, "R1 primary index readback");
    opWrite(4'h9, 8'h2A);
    opRead(4'h9, 8'h2A, "R1 secondary index readback");
    opRead(4'h1, 8'h15, "R1 primary index kept");

    // R2 timing registers, both drives, per channel
    regWrite(1'b0, 8'h0C, 8'hA1);
    regWrite(1'b0, 8'h13, 8'hB2);
    regWrite(1'b0, 8'h14, 8'hC3);
    regWrite(1'b0, 8'h1B, 8'hD4);
    regWrite(1'b1, 8'h0C, 8'h5E);
    regWrite(1'b0, 8'h10, 8'hCD);
    regWrite(1'b0, 8'h10, 8'h4D);
    regRead(1'b0, 8'h0C, 8'hA1, "R2 drive0 first timing");
    regRead(1'b0, 8'h13, 8'hB2, "R2 drive0 last timing");
    regRead(1'b0, 8'h14, 8'hC3, "R2 drive1 first timing");
    regRead(1'b0, 8'h1B, 8'hD4, "R2 drive1 last timing");
    regRead(1'b1, 8'h0C, 8'h5E, "R2 secondary timing separate");
    regRead(1'b0, 8'h10, 8'h4D, "R2 hold bit cleared");

    // R7 cable sense
    regRead(1'b0, 8'h0B, 8'h04, "R7 primary 40-conductor");
    regRead(1'b1, 8'h0B, 8'h00, "R7 secondary 80-conductor");
    regWrite(1'b0, 8'h0B, 8'hFF);
    regRead(1'b0, 8'h0B, 8'h04, "R7 write ignored");

    // R8 PLL bytes
    regWrite(1'b1, 8'h02, 8'h3C);
    regWrite(1'b1, 8'h03, 8'h0D);
    opIdle(1);
    check(pllF, 8'h3C, "R8 pllF port");
    check(pllR, 8'h0D, "R8 pllR port");
    regRead(1'b1, 8'h02, 8'h3C, "R8 F readback");
    regRead(1'b1, 8'h03, 8'h0D, "R8 R readback");
    regWrite(1'b0, 8'h02, 8'h77);
    regRead(1'b0, 8'h02, 8'h00, "R8 primary F unimplemented");
    opIdle(1);
    check(pllF, 8'h3C, "R8 pllF unaffected by primary");

    // R9 unimplemented indices and offsets
    regWrite(1'b0, 8'h05, 8'h99);
    regRead(1'b0, 8'h05, 8'h00, "R9 unimplemented index");
    regWrite(1'b0, 8'h1C, 8'h99);
    regRead(1'b0, 8'h1C, 8'h00, "R9 index past timing");
    opRead(4'h0, 8'h00, "R9 offset 0");
    opRead(4'hA, 8'h00, "R9 offset 2");

    // R11 no data without a read
    opIdle(2);
    check({7'd0, rdValid}, 8'h00, "R11 rdValid idle");

    // R3 control byte; bit 6 clear keeps counter still
    regWrite(1'b0, 8'h01, 8'h81);
    regRead(1'b0, 8'h01, 8'h81, "R3 ctrl readback");
    regWrite(1'b1, 8'h01, 8'h40);
    opIdle(20);
    regRead(1'b1, 8'h01, 8'h40, "R3 secondary ctrl readback");
    readCounter(Init, "R3 secondary test bit no effect");
    regWrite(1'b1, 8'h01, 8'h00);

    // R6 view writes ignored
    regWrite(1'b0, 8'h20, 8'h00);
    regWrite(1'b1, 8'h21, 8'h55);
    readCounter(Init, "R6 view writes ignored");

    // R4 first run: 0x11 decrements -> 0x7FFF (crosses slice split)
    runCounter(16);
    readCounter(30'h0000_7FFF, "R4 decrement count");
    opIdle(30);
    readCounter(30'h0000_7FFF, "R4 hold when disabled");

    // R5 second run: 0x8000 decrements -> wrap to all ones
    runCounter(32'h7FFF);
    readCounter(30'h3FFF_FFFF, "R5 wrap from zero");

    opIdle(4);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R11: actual=%0d pending reads expected=0", expQ.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule